// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a processor read a serial NOR flash as if it were ordinary memory. Software first loads a read template into a 32-bit template register. The template gives the flash read opcode, how many address bytes follow it, how many dummy bytes come next, and whether the data phase uses one, two or four lanes. A valid template write arms the engine, and the memory-mode status output goes high. From then on, each read request on the window port sends one complete flash read frame to the flash and returns one data word. A status-reset pulse drops memory mode. Reads that arrive while memory mode is off complete at once with an error and never select the flash.

The read port follows valid/ready rules. `rd_ready` is high only while the engine is idle, so at most one read is in flight. A request is taken on a clock where both `rd_valid` and `rd_ready` are high. The response waits behind back-pressure. `rsp_valid` stays high, and `rsp_data` and `rsp_err` stay unchanged, until the clock where `rsp_ready` is also high. The bus side therefore stalls until the last data bit has been sampled from the flash. The flash side runs in clock mode 0 at half the system clock rate.

Top module: `flash_xip_engine`

## Requirements
- R1: The template word has these fields. Bits [31:24] are the opcode, [23:21] the frame form, [20:19] the lane form and [18:16] the dummy byte count. Bits [15:0] have no effect.
- R2: Writing a template whose frame form is 2, 3, 4 or 5 stores it and raises `mem_mode` on the next cycle.
- R3: A template write with a frame form outside 2..5 is ignored. `mem_mode` and the stored template both keep their old values.
- R4: A `stat_reset` pulse clears `mem_mode` on the next cycle. It takes priority over a template write in the same cycle, and that write is then lost.
- R5: A read accepted while `mem_mode` is 0 returns `rsp_err`=1 with `rsp_data`=0, and `fl_cs_n` never goes low for it.
- R6: A frame sends the opcode and then (frame form − 1) address bytes, most significant bit first, on `fl_io_out[0]`. The address is `rd_addr` zero-extended and cut to that many low-order bytes.
- R7: After the address, the engine gives 8 × (dummy count) clocks. Then it gives DATA_W / lanes data clocks, and only after the last of them does `fl_cs_n` rise.
- R8: A lane form of 1 selects a wide data phase. With `wide_dual`=1 it uses two lanes on io[1:0], with io[1] carrying the higher bit. With `wide_dual`=0 it uses four lanes on io[3:0]. Every other lane form reads serially on io[1]. Within each byte, bits arrive MSB first.
- R9: A response word holds DATA_W/8 bytes from consecutive flash addresses. The first byte received lands in bits [7:0].
- R10: `fl_sck` is low whenever `fl_cs_n` is high. Outputs change on the falling edge and inputs are sampled on the rising edge. All `fl_io_oe` bits are 0 during the data phase.
- R11: `rd_ready` is low while a read is in flight. A response held back by `rsp_ready`=0 keeps its valid, data and error values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mcmd_we | input | 1 | Template register write strobe |
| mcmd_wdata | input | 32 | Template word |
| stat_reset | input | 1 | Pulse that drops memory mode |
| wide_dual | input | 1 | Wide data phase uses 2 lanes (1) or 4 lanes (0) |
| mem_mode | output | 1 | Memory mode active |
| rd_valid | input | 1 | Window read request valid |
| rd_ready | output | 1 | Engine can accept a read |
| rd_addr | input | ADDR_W | Byte offset within the window |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | DATA_W | Assembled read word |
| rsp_err | output | 1 | Read refused, memory mode off |
| fl_sck | output | 1 | Flash serial clock |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_io_out | output | 4 | Flash lane output values |
| fl_io_oe | output | 4 | Flash lane output enables |
| fl_io_in | input | 4 | Flash lane input values |

## Verification
The bench goes after address truncation at one and four address bytes. An engine that ignores the frame form would send the wrong number of address bytes, and the flash model would see a shifted opcode or address. It also checks dual and quad data phases with dummy bytes, plus a read that crosses a 64 KiB boundary. A lane or byte-order slip would show up there as a swapped word or a wrong clock count at deselect. Rejected frame forms and a reset that lands in the same cycle as a write are checked so that an engine arming too eagerly is caught. Error reads and held responses catch any design that touches the flash without memory mode or lets data drift under back-pressure.

// File: rtl/flash_xip_pkg.sv
package flash_xip_pkg;

  // template field positions (software-visible layout)
  localparam int OP_LSB    = 24;
  localparam int FRAME_LSB = 21;
  localparam int LANE_LSB  = 19;
  localparam int DUM_LSB   = 16;

  localparam logic [2:0] FRAME_MIN = 3'd2;
  localparam logic [2:0] FRAME_MAX = 3'd5;

  typedef struct packed {
    logic [7:0] op;
    logic [2:0] frame;
    logic [1:0] lane;
    logic [2:0] dummy;
  } tmpl_t;

  typedef enum logic [1:0] {LN_1 = 2'd0, LN_2 = 2'd1, LN_4 = 2'd2} lanes_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_DUMMY, ST_DATA, ST_RESP
  } seq_st_t;

  function automatic tmpl_t unpack_tmpl(input logic [31:0] w);
    tmpl_t t;
    t.op    = w[OP_LSB +: 8];
    t.frame = w[FRAME_LSB +: 3];
    t.lane  = w[LANE_LSB +: 2];
    t.dummy = w[DUM_LSB +: 3];
    return t;
  endfunction

  function automatic int lane_bits(input lanes_t l);
    return (l == LN_4) ? 4 : ((l == LN_2) ? 2 : 1);
  endfunction

endpackage

// File: rtl/flash_xip_mode.sv
module flash_xip_mode
  import flash_xip_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mcmd_we,
  input  logic [31:0] mcmd_wdata,
  input  logic        stat_reset,
  output logic        mem_mode,
  output tmpl_t       tmpl
);

  tmpl_t wr_t;
  logic  frame_ok;
  logic  unused_low;

  assign wr_t       = unpack_tmpl(mcmd_wdata);
  assign frame_ok   = (wr_t.frame >= FRAME_MIN) && (wr_t.frame <= FRAME_MAX);
  assign unused_low = ^mcmd_wdata[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_mode <= 1'b0;
      tmpl     <= '0;
    end else if (stat_reset) begin
      mem_mode <= 1'b0;
    end else if (mcmd_we && frame_ok) begin
      mem_mode <= 1'b1;
      tmpl     <= wr_t;
    end
  end

  AST_MODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    mcmd_we && frame_ok && !stat_reset |=> mem_mode); // R2
  AST_MODE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    stat_reset |=> !mem_mode); // R4
  AST_BAD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    mcmd_we && !frame_ok && !stat_reset |=> $stable(mem_mode) && $stable(tmpl)); // R3

endmodule

// File: rtl/flash_xip_rxasm.sv
module flash_xip_rxasm
  import flash_xip_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  lanes_t            lanes,
  input  logic [3:0]        io_in,
  output logic [DATA_W-1:0] word
);

  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sh <= '0;
    end else if (sample) begin
      case (lanes)
        LN_4:    sh <= {sh[DATA_W-5:0], io_in};
        LN_2:    sh <= {sh[DATA_W-3:0], io_in[1:0]};
        default: sh <= {sh[DATA_W-2:0], io_in[1]};
      endcase
    end
  end

  // the first byte on the wire ends up in the top of sh; move it to byte 0
  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign word[8*b +: 8] = sh[DATA_W-8*(b+1) +: 8];
  end

endmodule

// File: rtl/flash_xip_seq.sv
module flash_xip_seq
  import flash_xip_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_mode,
  input  tmpl_t             tmpl,
  input  logic              wide_dual,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic              accept,
  output logic              sample,
  output lanes_t            lanes_q,
  output logic              fl_sck,
  output logic              fl_cs_n,
  output logic [3:0]        fl_io_out,
  output logic [3:0]        fl_io_oe
);

  localparam int CNT_W = $clog2(DATA_W + 64);
  localparam int TX_W  = 40;

  seq_st_t          st;
  logic             half;
  logic [CNT_W-1:0] cnt;
  logic [TX_W-1:0]  tx;
  logic [2:0]       dum_q;
  logic [31:0]      addr_ext;
  logic [31:0]      addr_al;
  logic [CNT_W-1:0] data_last;

  assign addr_ext  = 32'(rd_addr);
  assign addr_al   = addr_ext << (8 * (5 - int'(tmpl.frame)));
  assign data_last = CNT_W'(DATA_W / lane_bits(lanes_q) - 1);

  assign rd_ready  = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
  assign accept    = rd_valid && rd_ready;
  assign sample    = (st == ST_DATA) && !half;
  assign fl_io_out = {3'b000, tx[TX_W-1]};
  assign fl_io_oe  = (st == ST_CMD || st == ST_DUMMY) ? 4'b0001 : 4'b0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      half    <= 1'b0;
      cnt     <= '0;
      tx      <= '0;
      dum_q   <= '0;
      lanes_q <= LN_1;
      rsp_err <= 1'b0;
      fl_sck  <= 1'b0;
      fl_cs_n <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: begin
          if (rd_valid) begin
            if (!mem_mode) begin
              rsp_err <= 1'b1;
              st      <= ST_RESP;
            end else begin
              rsp_err <= 1'b0;
              dum_q   <= tmpl.dummy;
              lanes_q <= (tmpl.lane == 2'd1) ? (wide_dual ? LN_2 : LN_4) : LN_1;
              tx      <= {tmpl.op, addr_al};
              cnt     <= CNT_W'(8 * int'(tmpl.frame) - 1);
              half    <= 1'b0;
              fl_sck  <= 1'b0;
              fl_cs_n <= 1'b0;
              st      <= ST_CMD;
            end
          end
        end
        ST_RESP: begin
          if (rsp_ready) begin
            rsp_err <= 1'b0;
            st      <= ST_IDLE;
          end
        end
        default: begin
          if (!half) begin
            half   <= 1'b1;
            fl_sck <= 1'b1;
          end else begin
            half   <= 1'b0;
            fl_sck <= 1'b0;
            tx     <= tx << 1;
            if (cnt != '0) begin
              cnt <= cnt - 1'b1;
            end else if (st == ST_CMD && dum_q != 3'd0) begin
              cnt <= CNT_W'(8 * int'(dum_q) - 1);
              st  <= ST_DUMMY;
            end else if (st != ST_DATA) begin
              cnt <= data_last;
              st  <= ST_DATA;
            end else begin
              fl_cs_n <= 1'b1;
              st      <= ST_RESP;
            end
          end
        end
      endcase
    end
  end

  AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && !mem_mode |=> rsp_valid && rsp_err && fl_cs_n); // R5
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cs_n |-> !fl_sck); // R10
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_cs_n |-> !rd_ready && !rsp_valid); // R11

endmodule

// File: rtl/flash_xip_engine.sv
module flash_xip_engine
  import flash_xip_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mcmd_we,
  input  logic [31:0]       mcmd_wdata,
  input  logic              stat_reset,
  input  logic              wide_dual,
  output logic              mem_mode,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              fl_sck,
  output logic              fl_cs_n,
  output logic [3:0]        fl_io_out,
  output logic [3:0]        fl_io_oe,
  input  logic [3:0]        fl_io_in
);

  tmpl_t  tmpl;
  logic   accept;
  logic   sample;
  lanes_t lanes;

  flash_xip_mode u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mcmd_we    (mcmd_we),
    .mcmd_wdata (mcmd_wdata),
    .stat_reset (stat_reset),
    .mem_mode   (mem_mode),
    .tmpl       (tmpl)
  );

  flash_xip_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_mode  (mem_mode),
    .tmpl      (tmpl),
    .wide_dual (wide_dual),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .accept    (accept),
    .sample    (sample),
    .lanes_q   (lanes),
    .fl_sck    (fl_sck),
    .fl_cs_n   (fl_cs_n),
    .fl_io_out (fl_io_out),
    .fl_io_oe  (fl_io_oe)
  );

  flash_xip_rxasm #(.DATA_W(DATA_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .sample (sample),
    .lanes  (lanes),
    .io_in  (fl_io_in),
    .word   (rsp_data)
  );

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err)); // R11
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_data == '0); // R5

endmodule

// File: tb/test_flash_xip_engine.sv
`timescale 1ns/1ps
module test_flash_xip_engine;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mcmd_we = 1'b0;
  logic [31:0]       mcmd_wdata = '0;
  logic              stat_reset = 1'b0;
  logic              wide_dual = 1'b0;
  logic              mem_mode;
  logic              rd_valid = 1'b0;
  logic              rd_ready;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b0;
  logic [DATA_W-1:0] rsp_data;
  logic              rsp_err;
  logic              fl_sck;
  logic              fl_cs_n;
  logic [3:0]        fl_io_out;
  logic [3:0]        fl_io_oe;
  logic [3:0]        fl_io_in = '0;

  flash_xip_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_flash_xip_engine (
    .clk(clk), .rst_n(rst_n), .mcmd_we(mcmd_we), .mcmd_wdata(mcmd_wdata),
    .stat_reset(stat_reset), .wide_dual(wide_dual), .mem_mode(mem_mode),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .fl_sck(fl_sck), .fl_cs_n(fl_cs_n),
    .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe), .fl_io_in(fl_io_in)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int unsigned a);
    return 8'((a * 29 + 11) ^ (a >> 8));
  endfunction

  function automatic int unsigned amask(input int nab);
    return (nab >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nab)) - 1);
  endfunction

  function automatic logic [31:0] tw(input int op, input int frame, input int lane, input int dum);
    return (32'(op) << 24) | (32'(frame) << 21) | (32'(lane) << 19) | (32'(dum) << 16);
  endfunction

  // behavioural reference: mode, template, outstanding reads
  typedef struct {
    int unsigned addr;
    int op;
    int nab;
    int dum;
    int lanes;
    bit err;
    int frames;
  } exp_t;

  exp_t q[$];
  bit   m_mode = 0;
  int   m_op = 0, m_frame = 0, m_lane = 0, m_dum = 0;
  int   frames = 0;
  int   last_op = -1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_op = 0; m_frame = 0; m_lane = 0; m_dum = 0;
    end else begin
      if (rd_valid && rd_ready) begin
        exp_t e;
        e.err    = !m_mode;
        e.op     = m_op;
        e.nab    = m_frame - 1;
        e.dum    = m_dum;
        e.lanes  = (m_lane == 1) ? (wide_dual ? 2 : 4) : 1;
        e.addr   = 32'(rd_addr) & amask(m_frame - 1);
        e.frames = frames;
        q.push_back(e);
      end
      if (stat_reset) m_mode = 0;
      else if (mcmd_we && mcmd_wdata[23:21] >= 3'd2 && mcmd_wdata[23:21] <= 3'd5) begin
        m_mode  = 1;
        m_op    = int'(mcmd_wdata[31:24]);
        m_frame = int'(mcmd_wdata[23:21]);
        m_lane  = int'(mcmd_wdata[20:19]);
        m_dum   = int'(mcmd_wdata[18:16]);
      end
    end
  end

  // behavioural flash
  int          fclk = 0;
  logic [39:0] fcmd = '0;
  int          oe_bad = 0;

  always @(negedge fl_cs_n) begin
    fclk = 0; fcmd = '0; oe_bad = 0; frames++;
  end

  always @(posedge fl_sck) begin
    if (!fl_cs_n && q.size() > 0) begin
      if (fclk < 8 * (q[0].nab + 1)) fcmd = {fcmd[38:0], fl_io_out[0]};
      else if (fclk >= 8 * (q[0].nab + 1) + 8 * q[0].dum && fl_io_oe != 4'b0) oe_bad++;
      fclk++;
    end
  end

  always @(negedge fl_sck) begin
    if (!fl_cs_n && q.size() > 0) begin : drv
      int pre, b, bit_i;
      int unsigned ac;
      logic [7:0] by, v;
      pre = 8 * (q[0].nab + 1) + 8 * q[0].dum;
      if (fclk >= pre) begin
        b     = q[0].lanes;
        bit_i = (fclk - pre) * b;
        ac    = int'(fcmd[31:0]) & amask(q[0].nab);
        by    = fbyte(ac + bit_i / 8);
        v     = (by >> (8 - (bit_i % 8) - b)) & 8'((1 << b) - 1);
        if (b == 1) fl_io_in = {2'b00, v[0], 1'b0};
        else        fl_io_in = v[3:0];
      end
    end
  end

  always @(posedge fl_cs_n) begin
    if (q.size() > 0) begin : fin
      int nab;
      nab = q[0].nab;
      last_op = int'(8'(fcmd >> (8 * nab)));
      chk(last_op == q[0].op, "R6 opcode", last_op, q[0].op);
      chk((int'(fcmd[31:0]) & amask(nab)) == q[0].addr, "R6 address",
          int'(fcmd[31:0]) & amask(nab), q[0].addr);
      chk(fclk == 8 * (nab + 1) + 8 * q[0].dum + DATA_W / q[0].lanes, "R7 clock count",
          fclk, 8 * (nab + 1) + 8 * q[0].dum + DATA_W / q[0].lanes);
      chk(oe_bad == 0, "R10 io_oe in data phase", oe_bad, 0);
    end
  end

  // per-clock comparison against the reference
  bit               hold_v = 0;
  logic [DATA_W-1:0] hold_d = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(mem_mode == m_mode, "R2 mem_mode vs model", mem_mode, m_mode);
      if (fl_cs_n) chk(!fl_sck, "R10 sck idle low", fl_sck, 0);
      if (hold_v && rsp_valid)
        chk(rsp_data == hold_d, "R11 held data stable", rsp_data, hold_d);
      hold_v = rsp_valid && !rsp_ready;
      hold_d = rsp_data;
      if (rsp_valid && rsp_ready) begin
        if (q.size() == 0) chk(0, "R11 response without request", 1, 0);
        else begin : pop
          exp_t e;
          logic [DATA_W-1:0] ed;
          e = q.pop_front();
          chk(rsp_err == e.err, "R5 error flag", rsp_err, e.err);
          if (e.err) begin
            chk(rsp_data == '0, "R5 error data", rsp_data, 0);
            chk(frames == e.frames, "R5 no flash frame", frames, e.frames);
          end else begin
            for (int k = 0; k < DATA_W / 8; k++) ed[8*k +: 8] = fbyte(e.addr + k);
            chk(rsp_data == ed, "R9 R8 data word", rsp_data, ed);
            chk(frames == e.frames + 1, "R7 one frame per read", frames, e.frames + 1);
          end
        end
      end
    end
  end

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic wr_tmpl(input logic [31:0] w);
    mcmd_we = 1'b1; mcmd_wdata = w; step(); mcmd_we = 1'b0; step();
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input int hold);
    int t;
    rd_valid = 1'b1; rd_addr = a;
    while (!rd_ready) step();
    step();
    rd_valid = 1'b0;
    chk(!rd_ready, "R11 ready low while busy", rd_ready, 0);
    t = 0;
    while (!rsp_valid && t < 3000) begin step(); t++; end
    repeat (hold) step();
    rsp_ready = 1'b1; step(); rsp_ready = 1'b0; step();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) step();
    rst_n = 1'b1;
    step();
    chk(mem_mode == 0, "R2 reset mode off", mem_mode, 0);
    chk(fl_cs_n == 1 && fl_sck == 0, "R10 reset flash idle", {fl_cs_n, fl_sck}, 2'b10);
    chk(rd_ready == 1 && rsp_valid == 0, "R11 reset handshake", {rd_ready, rsp_valid}, 2'b10);

    do_read(24'h000010, 0);                       // R5: mode off
    wr_tmpl(tw(8'h03, 1, 0, 0));
    chk(mem_mode == 0, "R3 frame form 1 rejected", mem_mode, 0);
    wr_tmpl(tw(8'h03, 6, 0, 0));
    chk(mem_mode == 0, "R3 frame form 6 rejected", mem_mode, 0);

    wr_tmpl(tw(8'h03, 4, 0, 0) | 32'h0000_A5C3);  // R1: junk in low bits
    chk(mem_mode == 1, "R2 armed", mem_mode, 1);
    do_read(24'h123456, 0);
    chk(last_op == 8'h03, "R1 opcode field", last_op, 8'h03);

    wr_tmpl(tw(8'h0B, 2, 0, 1));                  // R6: one address byte, one dummy byte
    do_read(24'hABCDEF, 2);
    wr_tmpl(tw(8'h13, 5, 0, 0));                  // R6: four address bytes
    do_read(24'h0F0E0D, 0);

    wide_dual = 1'b1;
    wr_tmpl(tw(8'h3B, 4, 1, 1));                  // R8: dual
    do_read(24'h000100, 3);
    wide_dual = 1'b0;
    wr_tmpl(tw(8'h6B, 4, 1, 2));                  // R8: quad, crosses 64 KiB
    do_read(24'h00FFFE, 5);
    wr_tmpl(tw(8'h03, 4, 2, 0));                  // R8: lane form 2 is serial
    do_read(24'h0A0B0C, 1);

    wr_tmpl(tw(8'h77, 7, 0, 0));                  // R3: ignored while armed
    chk(mem_mode == 1, "R3 mode kept", mem_mode, 1);
    do_read(24'h000200, 0);
    chk(last_op == 8'h03, "R3 template kept", last_op, 8'h03);

    stat_reset = 1'b1; step(); stat_reset = 1'b0; step();
    chk(mem_mode == 0, "R4 reset drops mode", mem_mode, 0);
    do_read(24'h000300, 2);                       // R5 after reset

    stat_reset = 1'b1; mcmd_we = 1'b1; mcmd_wdata = tw(8'hEB, 4, 0, 0);
    step();
    stat_reset = 1'b0; mcmd_we = 1'b0; step();
    chk(mem_mode == 0, "R4 reset beats write", mem_mode, 0);

    wr_tmpl(tw(8'h0B, 3, 0, 3));
    do_read(24'hFEDCBA, 0);
    chk(last_op == 8'h0B, "R6 rearmed opcode", last_op, 8'h0B);

    repeat (5) step();
    chk(q.size() == 0, "R11 all reads answered", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule